// File: doc/BRIEF.md
# Reset Configuration Word Selector

This block builds the 32-bit word that fixes a chip's operating mode coming out of hard reset. It chooses between three sources: the external data pins, a word held in non-volatile storage, or an all-zero built-in default. The choice is made by a strap input and by a flag that tells whether the non-volatile word is valid. While hard reset is held, the chosen source is sampled periodically into a two-stage buffer. The word is frozen when hard reset ends, so a slow or noisy source cannot corrupt it.

During power-on reset the output is the zero default. At the clock edge that ends hard reset, the frozen word appears together with a one-cycle valid strobe. Two fields of the frozen word are decoded for neighbouring logic: the boot port width and the chip/bus mode. The block also drives the enable of a weak pull-down on the data pins, so that undriven pins read as zero while the pins are the selected source.

Top module: `rcw_select`

## Requirements
- R1: While `por_n` is low, `cfg_word_o` is 0 and `cfg_valid_o` is 0 (asynchronously). After release, the word stays 0 until the first hard reset ends.
- R2: The source is chosen as follows. With `strap_ext_i`=1 it is `pins_i`. With `strap_ext_i`=0 and `nv_absent_i`=0 it is `nv_word_i`. With `strap_ext_i`=0 and `nv_absent_i`=1 it is 32'h0000_0000.
- R3: The word is updated at the first rising edge that sees `hard_rst_i`=0 after an edge that saw it at 1. Between such edges `cfg_word_o` holds, whatever the source inputs do.
- R4: While `hard_rst_i`=1, the source is sampled once every 8 clocks into a two-stage buffer, and the word is taken from the second stage. A source held stable for at least the last 16 clocks of a hard reset pulse is taken. A source change within the last 7 clocks is not taken; the value that was stable before it is used.
- R5: `cfg_valid_o` is 1 for exactly one cycle, in the same cycle that `cfg_word_o` shows the newly frozen word.
- R6: `pulldown_o` = `pd_ctl_i` AND `hard_rst_i` AND `strap_ext_i`, combinationally.
- R7: The boot port field is word bits 27:26, with bit 27 as the field's most significant bit. `port_sz_o` gives 00 for a 32-bit port, 01 for an 8-bit port and 10 for a 16-bit port.
- R8: A boot port field of 11 (reserved) sets `port_sz_err_o`=1 and gives `port_sz_o`=00, which selects the 32-bit port. Any other field value gives `port_sz_err_o`=0.
- R9: The chip mode field is word bits 14:13, with bit 14 as the field's most significant bit. The codes decode as follows. 00: all three mode outputs are 0 (extended chip, 32-bit data). 01: `bus16_o`=1 (extended chip, 16-bit data). 10: `single_chip_o`=1 and `show_cyc_o`=1. 11: `single_chip_o`=1 only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asserted asynchronously, released synchronously inside the block |
| hard_rst_i | input | 1 | Hard reset active (synchronous to clk) |
| strap_ext_i | input | 1 | Strap: 1 takes the word from the data pins |
| nv_absent_i | input | 1 | 1 when the non-volatile word is not valid |
| pins_i | input | 32 | External data pins |
| nv_word_i | input | 32 | Non-volatile configuration word |
| pd_ctl_i | input | 1 | Pull-down permission bit |
| pulldown_o | output | 1 | Weak pull-down enable for the data pins |
| cfg_word_o | output | 32 | Frozen configuration word |
| cfg_valid_o | output | 1 | One-cycle strobe when a new word is frozen |
| port_sz_o | output | 2 | Decoded boot port width |
| port_sz_err_o | output | 1 | Boot port field held the reserved code |
| bus16_o | output | 1 | Extended chip with 16-bit data |
| single_chip_o | output | 1 | Single-chip mode |
| show_cyc_o | output | 1 | Single-chip mode with address show cycles |

## Verification
A periodic sample tick can land in the same cycle as the last cycle of hard reset, and the source can change in that same window. The bench provokes this in two ways. It sweeps the pulse length over all eight phases of the sample period. It also swaps the pin value one to seven clocks before the negation. The frozen word must always equal the value that was stable before the swap, never the late one. Random pulses of varied length and random sources are judged against a bench function of the strap and valid-flag priority.

// File: rtl/rcw_pkg.sv
package rcw_pkg;
  // Source selection codes
  typedef enum logic [1:0] {
    SRC_PINS = 2'b00,
    SRC_NV   = 2'b01,
    SRC_ZERO = 2'b10
  } src_e;

  // Boot port width codes
  localparam logic [1:0] PSZ_32  = 2'b00;
  localparam logic [1:0] PSZ_8   = 2'b01;
  localparam logic [1:0] PSZ_16  = 2'b10;
  localparam logic [1:0] PSZ_RSV = 2'b11;

  // Chip mode codes
  localparam logic [1:0] CM_EXT32    = 2'b00;
  localparam logic [1:0] CM_EXT16    = 2'b01;
  localparam logic [1:0] CM_SGL_SHOW = 2'b10;
  localparam logic [1:0] CM_SGL      = 2'b11;

  // Field starts, counted from the word's most significant bit
  localparam int PSZ_FROM_TOP = 4;
  localparam int CM_FROM_TOP  = 17;

  function automatic src_e pick_src(input logic strap, input logic nv_absent);
    if (strap)          return SRC_PINS;
    else if (!nv_absent) return SRC_NV;
    else                return SRC_ZERO;
  endfunction
endpackage

// File: rtl/rcw_rst_sync.sv
module rcw_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic por_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_n_o = sync_q[STAGES-1];
endmodule

// File: rtl/rcw_src_mux.sv
module rcw_src_mux #(
  parameter int WORD_W = 32
) (
  input  logic              strap_i,
  input  logic              nv_absent_i,
  input  logic [WORD_W-1:0] pins_i,
  input  logic [WORD_W-1:0] nv_word_i,
  output logic [WORD_W-1:0] src_o
);
  import rcw_pkg::*;

  src_e sel;

  always_comb begin
    sel = pick_src(strap_i, nv_absent_i);
    unique case (sel)
      SRC_PINS: src_o = pins_i;
      SRC_NV:   src_o = nv_word_i;
      default:  src_o = '0;
    endcase
  end
endmodule

// File: rtl/rcw_sampler.sv
module rcw_sampler #(
  parameter int WORD_W = 32,
  parameter int PERIOD = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hard_rst_i,
  input  logic [WORD_W-1:0] src_i,
  output logic [WORD_W-1:0] word_o,
  output logic              valid_o
);
  localparam int CNT_W = (PERIOD > 1) ? $clog2(PERIOD) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(PERIOD - 1);

  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [WORD_W-1:0] stg1_q, stg2_q;
  logic [WORD_W-1:0] word_q, word_d;
  logic              hard_q;
  logic              valid_q;
  logic              tick;
  logic              negation;

  always_comb begin
    tick     = hard_rst_i && (cnt_q == CNT_LAST);
    negation = hard_q && !hard_rst_i;
    if (!hard_rst_i)  cnt_d = '0;
    else if (tick)    cnt_d = '0;
    else              cnt_d = cnt_q + 1'b1;
    word_d = negation ? stg2_q : word_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      hard_q  <= 1'b0;
      valid_q <= 1'b0;
      word_q  <= '0;
    end else begin
      cnt_q   <= cnt_d;
      hard_q  <= hard_rst_i;
      valid_q <= negation;
      word_q  <= word_d;
    end
  end

  // Double buffer, advanced only on the sample tick
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg1_q <= '0;
      stg2_q <= '0;
    end else if (tick) begin
      stg1_q <= src_i;
      stg2_q <= stg1_q;
    end
  end

  assign word_o  = word_q;
  assign valid_o = valid_q;
endmodule

// File: rtl/rcw_decode.sv
module rcw_decode (
  input  logic [1:0] psz_field_i,
  input  logic [1:0] cm_field_i,
  output logic [1:0] port_sz_o,
  output logic       port_sz_err_o,
  output logic       bus16_o,
  output logic       single_chip_o,
  output logic       show_cyc_o
);
  import rcw_pkg::*;

  always_comb begin
    port_sz_err_o = (psz_field_i == PSZ_RSV);
    port_sz_o     = port_sz_err_o ? PSZ_32 : psz_field_i;
  end

  always_comb begin
    bus16_o       = 1'b0;
    single_chip_o = 1'b0;
    show_cyc_o    = 1'b0;
    unique case (cm_field_i)
      CM_EXT32:    ;
      CM_EXT16:    bus16_o = 1'b1;
      CM_SGL_SHOW: begin single_chip_o = 1'b1; show_cyc_o = 1'b1; end
      default:     single_chip_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/rcw_select.sv
module rcw_select #(
  parameter int WORD_W      = 32,
  parameter int PERIOD      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              hard_rst_i,
  input  logic              strap_ext_i,
  input  logic              nv_absent_i,
  input  logic [WORD_W-1:0] pins_i,
  input  logic [WORD_W-1:0] nv_word_i,
  input  logic              pd_ctl_i,
  output logic              pulldown_o,
  output logic [WORD_W-1:0] cfg_word_o,
  output logic              cfg_valid_o,
  output logic [1:0]        port_sz_o,
  output logic              port_sz_err_o,
  output logic              bus16_o,
  output logic              single_chip_o,
  output logic              show_cyc_o
);
  import rcw_pkg::*;

  localparam int PSZ_HI = WORD_W - 1 - PSZ_FROM_TOP;
  localparam int CM_HI  = WORD_W - 1 - CM_FROM_TOP;

  logic              rst_n;
  logic [WORD_W-1:0] src;

  rcw_rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .por_n   (por_n),
    .rst_n_o (rst_n)
  );

  rcw_src_mux #(.WORD_W(WORD_W)) u_mux (
    .strap_i     (strap_ext_i),
    .nv_absent_i (nv_absent_i),
    .pins_i      (pins_i),
    .nv_word_i   (nv_word_i),
    .src_o       (src)
  );

  rcw_sampler #(.WORD_W(WORD_W), .PERIOD(PERIOD)) u_smp (
    .clk        (clk),
    .rst_n      (rst_n),
    .hard_rst_i (hard_rst_i),
    .src_i      (src),
    .word_o     (cfg_word_o),
    .valid_o    (cfg_valid_o)
  );

  rcw_decode u_dec (
    .psz_field_i   (cfg_word_o[PSZ_HI -: 2]),
    .cm_field_i    (cfg_word_o[CM_HI -: 2]),
    .port_sz_o     (port_sz_o),
    .port_sz_err_o (port_sz_err_o),
    .bus16_o       (bus16_o),
    .single_chip_o (single_chip_o),
    .show_cyc_o    (show_cyc_o)
  );

  assign pulldown_o = pd_ctl_i & hard_rst_i & strap_ext_i;
endmodule

// File: rtl/rcw_select_chk.sv
module rcw_select_chk #(
  parameter int WORD_W = 32
) (
  input logic              clk,
  input logic              por_n,
  input logic              hard_rst_i,
  input logic [WORD_W-1:0] cfg_word_o,
  input logic              cfg_valid_o,
  input logic [1:0]        port_sz_o,
  input logic              port_sz_err_o,
  input logic              bus16_o,
  input logic              single_chip_o,
  input logic              show_cyc_o
);
  assert_valid_after_neg_R5: assert property (@(posedge clk) disable iff (!por_n)
    cfg_valid_o |-> (!$past(hard_rst_i) && $past(hard_rst_i, 2)));

  assert_valid_single_R5: assert property (@(posedge clk) disable iff (!por_n)
    cfg_valid_o |=> !cfg_valid_o);

  assert_word_hold_R3: assert property (@(posedge clk) disable iff (!por_n)
    !cfg_valid_o |-> $stable(cfg_word_o));

  assert_rsv_is_wide_R8: assert property (@(posedge clk) disable iff (!por_n)
    port_sz_err_o |-> (port_sz_o == 2'b00));

  assert_show_mode_R9: assert property (@(posedge clk) disable iff (!por_n)
    show_cyc_o |-> (single_chip_o && !bus16_o));
endmodule

bind rcw_select rcw_select_chk #(.WORD_W(WORD_W)) u_chk (
  .clk           (clk),
  .por_n         (por_n),
  .hard_rst_i    (hard_rst_i),
  .cfg_word_o    (cfg_word_o),
  .cfg_valid_o   (cfg_valid_o),
  .port_sz_o     (port_sz_o),
  .port_sz_err_o (port_sz_err_o),
  .bus16_o       (bus16_o),
  .single_chip_o (single_chip_o),
  .show_cyc_o    (show_cyc_o)
);

// File: tb/test_rcw_select.sv
`timescale 1ns/1ps
module test_rcw_select;
  logic        clk = 1'b0;
  logic        por_n, hard_rst_i, strap_ext_i, nv_absent_i, pd_ctl_i;
  logic [31:0] pins_i, nv_word_i;
  logic        pulldown_o, cfg_valid_o, port_sz_err_o, bus16_o, single_chip_o, show_cyc_o;
  logic [31:0] cfg_word_o;
  logic [1:0]  port_sz_o;
  int n_chk = 0;
  int n_err = 0;
  logic [31:0] last_word;

  always #2.5 clk = ~clk;

  rcw_select i_rcw_select (
    .clk(clk), .por_n(por_n), .hard_rst_i(hard_rst_i), .strap_ext_i(strap_ext_i),
    .nv_absent_i(nv_absent_i), .pins_i(pins_i), .nv_word_i(nv_word_i), .pd_ctl_i(pd_ctl_i),
    .pulldown_o(pulldown_o), .cfg_word_o(cfg_word_o), .cfg_valid_o(cfg_valid_o),
    .port_sz_o(port_sz_o), .port_sz_err_o(port_sz_err_o), .bus16_o(bus16_o),
    .single_chip_o(single_chip_o), .show_cyc_o(show_cyc_o));

  function automatic logic [31:0] exp_src(logic s, logic a, logic [31:0] p, logic [31:0] n);
    if (s) return p;
    if (!a) return n;
    return 32'h0;
  endfunction

  function automatic logic [2:0] exp_psz(logic [31:0] w); // {err, size}
    logic [1:0] f = w[27:26];
    return (f == 2'b11) ? 3'b100 : {1'b0, f};
  endfunction

  function automatic logic [2:0] exp_mode(logic [31:0] w); // {bus16, single, show}
    case (w[14:13])
      2'b00:   return 3'b000;
      2'b01:   return 3'b100;
      2'b10:   return 3'b011;
      default: return 3'b010;
    endcase
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  // Hard reset pulse of len clocks; late>0 swaps pins late clocks before the end
  task automatic pulse(int len, int late, logic [31:0] late_pins, logic [31:0] expw, string req);
    @(negedge clk); hard_rst_i = 1'b1;
    for (int c = 1; c < len; c++) begin
      @(negedge clk);
      if (late > 0 && c == len - late) pins_i = late_pins;
    end
    @(negedge clk); hard_rst_i = 1'b0;
    @(negedge clk);
    check({req, " word"}, cfg_word_o, expw);
    check("R5 valid high", {31'b0, cfg_valid_o}, 32'd1);
    check("R7 R8 port decode", {29'b0, port_sz_err_o, port_sz_o}, {29'b0, exp_psz(expw)});
    check("R9 mode decode", {29'b0, bus16_o, single_chip_o, show_cyc_o}, {29'b0, exp_mode(expw)});
    @(negedge clk);
    check("R5 valid drops", {31'b0, cfg_valid_o}, 32'd0);
    last_word = cfg_word_o;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'h1d5e_0a73));
    por_n = 1'b0; hard_rst_i = 1'b0; strap_ext_i = 1'b0; nv_absent_i = 1'b1;
    pd_ctl_i = 1'b0; pins_i = 32'hffff_ffff; nv_word_i = 32'hffff_ffff;
    repeat (3) @(negedge clk);
    check("R1 reset word", cfg_word_o, 32'h0);
    check("R1 reset valid", {31'b0, cfg_valid_o}, 32'd0);
    por_n = 1'b1;
    repeat (5) @(negedge clk);
    check("R1 zero after release", cfg_word_o, 32'h0);

    // R2: each source branch directed
    strap_ext_i = 1'b1; nv_absent_i = 1'b1; pins_i = 32'h1234_5678; nv_word_i = 32'hdead_beef;
    pulse(20, 0, 32'h0, 32'h1234_5678, "R2 pins");
    strap_ext_i = 1'b0; nv_absent_i = 1'b0;
    pulse(24, 0, 32'h0, 32'hdead_beef, "R2 nv");
    nv_absent_i = 1'b1;
    pulse(17, 0, 32'h0, 32'h0, "R2 zero");

    // R2 R4: random sources and pulse lengths
    for (int i = 0; i < 24; i++) begin
      strap_ext_i = 1'($urandom); nv_absent_i = 1'($urandom);
      pins_i = $urandom; nv_word_i = $urandom;
      pulse(16 + int'($urandom % 45), 0, 32'h0,
            exp_src(strap_ext_i, nv_absent_i, pins_i, nv_word_i), "R2 R4 random");
    end

    // R4: late pin change over every phase of the sample period
    strap_ext_i = 1'b1;
    for (int len = 16; len < 24; len++) begin
      for (int late = 1; late < 8; late += 3) begin
        logic [31:0] old_p;
        old_p = $urandom;
        pins_i = old_p;
        pulse(len, late, ~old_p, old_p, "R4 late change ignored");
      end
    end

    // R7 R8 R9: every field code
    for (int k = 0; k < 4; k++) begin
      logic [31:0] w;
      w = $urandom;
      w[27:26] = 2'(k); w[14:13] = 2'(3 - k);
      pins_i = w;
      pulse(18, 0, 32'h0, w, "R7 R8 R9 fields");
    end

    // R3: word holds while sources move with hard reset low
    for (int c = 0; c < 12; c++) begin
      @(negedge clk);
      strap_ext_i = 1'($urandom); nv_absent_i = 1'($urandom);
      pins_i = $urandom; nv_word_i = $urandom;
      #1;
      check("R3 hold word", cfg_word_o, last_word);
      check("R3 no strobe", {31'b0, cfg_valid_o}, 32'd0);
    end

    // R1: power-on reset mid-run returns the default
    @(negedge clk); por_n = 1'b0; #1;
    check("R1 default under por", cfg_word_o, 32'h0);
    @(negedge clk); por_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 default after por", cfg_word_o, 32'h0);

    // R6: pull-down over all input combinations
    for (int m = 0; m < 8; m++) begin
      @(negedge clk);
      pd_ctl_i = m[2]; hard_rst_i = m[1]; strap_ext_i = m[0];
      #1;
      check("R6 pulldown", {31'b0, pulldown_o}, {31'b0, (m == 7)});
    end
    @(negedge clk); hard_rst_i = 1'b0;
    repeat (2) @(negedge clk);
    summary();
    $finish;
  end
endmodule